// File: doc/BRIEF.md
# Shared-Destination Spike Packet Encoder

This block sits between the output layer of a 16-output spiking core and a mesh router. When one or more outputs fire, the block turns each spike into a series of 32-bit spike packets, one for every synaptic destination that belongs to that output. Destinations live in an external memory of 64 blocks of 16 entries each. The block reads that memory through its own combinational read port. Destination storage is shared. A 64-bit allocation row per output says which memory blocks the output owns, so one output can have many destinations and another none.

For each firing output, the encoder finds the allocated blocks one at a time with a priority search. It reads every entry of each found block and emits a packet for each valid entry. Each packet waits on a valid/acknowledge handshake until the router takes it. Spikes that arrive while a walk is running are kept in a pending register and are served afterwards.

Top module: `spike_pkt_encoder`

## Requirements
- R1: While reset is held, and afterwards until a spike arrives, `pkt_valid` and `mem_rd` stay low.
- R2: The packet carries destination X in bits 31:28 and destination Y in bits 27:24. Bits 23:21 hold the type code 3'b001, and bits 20:12 are zero. The neuron number sits in bits 11:8 and the weight in bits 7:0.
- R3: A memory entry is 21 bits wide: valid in bit 20, X in 19:16, Y in 15:12, neuron in 11:8 and weight in 7:0. The entry at block b, slot e is read at address b*16+e.
- R4: For a firing output, one packet is emitted for every valid entry of every block whose bit is set in that output's 64-bit allocation row (bit b = block b). Blocks are visited in ascending index and entries in ascending slot order.
- R5: Entries whose valid bit is clear produce no packet.
- R6: An output whose allocation row is all zero produces no packet.
- R7: Outputs that fire in the same cycle are served one after another in ascending output index.
- R8: A spike that arrives while a walk is in progress, including one on the output being walked, is held and served after the current walk. Pending outputs are again taken in ascending index.
- R9: A packet stays on `pkt_data` with `pkt_valid` high and unchanged until a cycle in which `pkt_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spike_in | input | 16 | One-cycle spike pulses, one bit per core output |
| alloc_table | input | 1024 | Allocation rows; output o owns block b when bit o*64+b is set |
| mem_rd | output | 1 | High while an entry is being read |
| mem_addr | output | 10 | Entry address, block*16 + slot |
| mem_rdata | input | 21 | Entry read combinationally at `mem_addr` |
| pkt_valid | output | 1 | Packet present on `pkt_data` |
| pkt_data | output | 32 | Spike packet |
| pkt_ack | input | 1 | Router accepts the packet on this cycle |

## Verification
Faults in the block position show up at the ports within one packet. A stuck or skipped block or slot counter either drops a destination or repeats one. It can also put a packet out of ascending order, and the next accepted packet then differs from the one the bench computes. A lost pending bit only shows once the running walk drains: the whole packet run for that output is missing, so the final count falls short. A handshake fault changes `pkt_data` during a stall in the very next cycle.

// File: rtl/spk_pkg.sv
// Shared constants for the spike packet encoder.
// Assumes a 32-bit packet whose type field is at bits 23:21.
package spk_pkg;
    localparam logic [2:0] PKT_TYPE_SPIKE = 3'b001;
    localparam int PKT_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_READ = 2'd2,
        ST_SEND = 2'd3
    } walk_state_t;
endpackage

// File: rtl/spk_lowbit.sv
// Finds the lowest set bit of a vector and reports whether any bit is set.
// Purely combinational; W is any width >= 2.
module spk_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/spk_pending.sv
// Holds spikes that wait for service. New pulses are OR-ed in every cycle.
// The served bit is cleared; a pulse on that same bit in the same cycle survives.
module spk_pending #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  spike_in,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  pend
);
    logic [N-1:0] clr_mask;

    // one-hot clear mask for the output taken into service
    generate
        for (genvar g = 0; g < N; g++) begin : g_mask
            assign clr_mask[g] = clr_en && (clr_idx == IW'(g));
        end
    endgenerate

    // accumulate new spikes, drop the one being served
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_mask) | spike_in;
    end
endmodule

// File: rtl/spk_pkt_fmt.sv
// Maps a destination entry into the outgoing packet layout.
// Assumes the field widths fit the fixed 32-bit packet positions.
module spk_pkt_fmt #(
    parameter int X_W   = 4,
    parameter int Y_W   = 4,
    parameter int NRN_W = 4,
    parameter int WT_W  = 8,
    parameter int ENT_W = 1 + X_W + Y_W + NRN_W + WT_W
) (
    input  logic [ENT_W-1:0]         entry,
    output logic [spk_pkg::PKT_W-1:0] pkt
);
    localparam int WT_LO  = 0;
    localparam int NRN_LO = WT_W;
    localparam int Y_LO   = NRN_LO + NRN_W;
    localparam int X_LO   = Y_LO + Y_W;

    // place each field at its packet position, unused bits zero
    always_comb begin
        pkt        = '0;
        pkt[31:28] = 4'(entry[X_LO +: X_W]);
        pkt[27:24] = 4'(entry[Y_LO +: Y_W]);
        pkt[23:21] = spk_pkg::PKT_TYPE_SPIKE;
        pkt[11:8]  = 4'(entry[NRN_LO +: NRN_W]);
        pkt[7:0]   = 8'(entry[WT_LO +: WT_W]);
    end
endmodule

// File: rtl/spike_pkt_encoder.sv
// Walks the destination blocks allocated to each firing output and emits one
// packet per valid entry over a valid/acknowledge handshake.
// Assumes mem_rdata answers mem_addr in the same cycle, and the allocation
// table is stable while a walk runs.
module spike_pkt_encoder #(
    parameter int N_OUT     = 16,
    parameter int N_BLK     = 64,
    parameter int BLK_DEPTH = 16,
    parameter int X_W       = 4,
    parameter int Y_W       = 4,
    parameter int NRN_W     = 4,
    parameter int WT_W      = 8,
    localparam int OUT_IW   = $clog2(N_OUT),
    localparam int BLK_IW   = $clog2(N_BLK),
    localparam int ENT_IW   = $clog2(BLK_DEPTH),
    localparam int ADDR_W   = BLK_IW + ENT_IW,
    localparam int ENT_W    = 1 + X_W + Y_W + NRN_W + WT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_OUT-1:0]          spike_in,
    input  logic [N_OUT*N_BLK-1:0]    alloc_table,
    output logic                      mem_rd,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic [ENT_W-1:0]          mem_rdata,
    output logic                      pkt_valid,
    output logic [spk_pkg::PKT_W-1:0] pkt_data,
    input  logic                      pkt_ack
);
    import spk_pkg::*;

    walk_state_t          state_q;
    logic [N_BLK-1:0]     rem_q;
    logic [BLK_IW-1:0]    blk_q;
    logic [ENT_IW-1:0]    ent_q;
    logic [N_OUT-1:0]     pend;
    logic                 pend_found;
    logic [OUT_IW-1:0]    pend_idx;
    logic                 blk_found;
    logic [BLK_IW-1:0]    blk_idx;
    logic [PKT_W-1:0]     fmt_pkt;
    logic                 take_out;
    logic                 last_ent;
    logic                 ent_valid;

    assign take_out  = (state_q == ST_IDLE) && pend_found;
    assign last_ent  = (ent_q == ENT_IW'(BLK_DEPTH - 1));
    assign ent_valid = mem_rdata[ENT_W-1];
    assign mem_rd    = (state_q == ST_READ);
    assign mem_addr  = {blk_q, ent_q};

    spk_pending #(.N(N_OUT)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .spike_in (spike_in),
        .clr_en   (take_out),
        .clr_idx  (pend_idx),
        .pend     (pend)
    );

    spk_lowbit #(.W(N_OUT)) u_out_sel (
        .vec   (pend),
        .found (pend_found),
        .idx   (pend_idx)
    );

    spk_lowbit #(.W(N_BLK)) u_blk_sel (
        .vec   (rem_q),
        .found (blk_found),
        .idx   (blk_idx)
    );

    spk_pkt_fmt #(.X_W(X_W), .Y_W(Y_W), .NRN_W(NRN_W), .WT_W(WT_W)) u_fmt (
        .entry (mem_rdata),
        .pkt   (fmt_pkt)
    );

    // walk controller: pick output, hop blocks, step slots, hold packets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            blk_q     <= '0;
            ent_q     <= '0;
            pkt_valid <= 1'b0;
            pkt_data  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pend_found) begin
                        rem_q   <= alloc_table[pend_idx*N_BLK +: N_BLK];
                        state_q <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (blk_found) begin
                        blk_q          <= blk_idx;
                        rem_q[blk_idx] <= 1'b0;
                        ent_q          <= '0;
                        state_q        <= ST_READ;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_READ: begin
                    if (ent_valid) begin
                        pkt_data  <= fmt_pkt;
                        pkt_valid <= 1'b1;
                        state_q   <= ST_SEND;
                    end else if (last_ent) begin
                        state_q <= ST_PICK;
                    end else begin
                        ent_q <= ent_q + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (pkt_ack) begin
                        pkt_valid <= 1'b0;
                        if (last_ent) begin
                            state_q <= ST_PICK;
                        end else begin
                            ent_q   <= ent_q + 1'b1;
                            state_q <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spike_pkt_encoder_chk.sv
// Port-level protocol checks for the spike packet encoder, attached by bind.
module spike_pkt_encoder_chk #(
    parameter int ENT_W = 21,
    parameter int WT_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_rd,
    input logic [ENT_W-1:0] mem_rdata,
    input logic             pkt_valid,
    input logic [31:0]      pkt_data,
    input logic             pkt_ack
);
    // R1: reset drives the packet interface idle on the next edge
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !pkt_valid);

    // R2: type code and zero padding on every presented packet
    assert_pkt_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_data[23:21] == spk_pkg::PKT_TYPE_SPIKE) && (pkt_data[20:12] == 9'd0));

    // R2: a fresh packet carries the weight of the entry read the cycle before
    assert_pkt_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> pkt_data[7:0] == 8'($past(mem_rdata[WT_W-1:0])));

    // R5: a packet only appears after a read of a valid entry
    assert_valid_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(mem_rd) && $past(mem_rdata[ENT_W-1]));

    // R9: a stalled packet stays put
    assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ack |=> pkt_valid && $stable(pkt_data));

    // no read while a packet waits for the router
    assert_no_read_while_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !mem_rd);
endmodule

bind spike_pkt_encoder spike_pkt_encoder_chk #(.ENT_W(ENT_W), .WT_W(WT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_rdata (mem_rdata),
    .pkt_valid (pkt_valid),
    .pkt_data  (pkt_data),
    .pkt_ack   (pkt_ack)
);

// File: tb/spike_pkt_encoder_bench.sv
module spike_pkt_encoder_bench;
    localparam int N_OUT = 16;
    localparam int N_BLK = 64;
    localparam int DEP   = 16;
    localparam int QMAX  = 8192;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N_OUT-1:0]       spike_in = '0;
    logic [N_OUT*N_BLK-1:0] alloc_table = '0;
    logic                   mem_rd;
    logic [9:0]             mem_addr;
    logic [20:0]            mem_rdata;
    logic                   pkt_valid;
    logic [31:0]            pkt_data;
    logic                   pkt_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int exp_wr = 0;
    int got = 0;
    int cyc = 0;
    logic stall_mode = 1'b0;
    logic [31:0] expq [QMAX];
    string cur_req = "R4";

    always #2 clk = ~clk;

    spike_pkt_encoder u_spike_pkt_encoder (
        .clk(clk), .rst_n(rst_n), .spike_in(spike_in), .alloc_table(alloc_table),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ack(pkt_ack)
    );

    // arithmetic destination memory (R3 entry layout)
    function automatic logic [20:0] ent_word(int a);
        logic v;
        v = ((a % 7) != 3) && ((a / DEP) != 2);
        return {v, 4'((a * 3) % 16), 4'((a / DEP) % 16), 4'(a % 16), 8'((a * 37 + 11) % 256)};
    endfunction

    function automatic logic alloc_bit(int o, int b);
        if (o == 5) return 1'b0;
        if (o == 0 && (b == 0 || b == 63)) return 1'b1;
        return ((b * 5 + o * 3) % 13) == 0;
    endfunction

    always_comb mem_rdata = ent_word(int'(mem_addr));

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // expected packets of one output (R2 layout, R4 order, R5 skip, R6 empty)
    task automatic push_out(input int o);
        for (int b = 0; b < N_BLK; b++) begin
            if (alloc_bit(o, b)) begin
                for (int e = 0; e < DEP; e++) begin
                    logic [20:0] w;
                    w = ent_word(b * DEP + e);
                    if (w[20]) begin
                        expq[exp_wr] = {w[19:16], w[15:12], 3'b001, 9'd0, w[11:8], w[7:0]};
                        exp_wr++;
                    end
                end
            end
        end
    endtask

    task automatic fire(input logic [N_OUT-1:0] m);
        @(negedge clk);
        spike_in = m;
        @(negedge clk);
        spike_in = '0;
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while (got < exp_wr && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (60) @(negedge clk);
        check(got == exp_wr, req, "packet count", 32'(got), 32'(exp_wr));
    endtask

    // router model and packet monitor
    initial begin
        logic held_v;
        logic [31:0] held_d;
        logic a;
        held_v = 1'b0;
        held_d = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (held_v)
                check(pkt_valid && pkt_data == held_d, "R9", "held packet", pkt_data, held_d);
            a = !stall_mode || ((cyc % 3) != 0);
            pkt_ack = a;
            if (pkt_valid && a) begin
                if (got < exp_wr)
                    check(pkt_data == expq[got], cur_req, "packet", pkt_data, expq[got]);
                else
                    check(1'b0, cur_req, "unexpected packet", pkt_data, 32'd0);
                got++;
            end
            held_v = pkt_valid && !a;
            held_d = pkt_data;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", got, exp_wr);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int o = 0; o < N_OUT; o++)
            for (int b = 0; b < N_BLK; b++)
                alloc_table[o * N_BLK + b] = alloc_bit(o, b);

        repeat (4) @(negedge clk);
        check(!pkt_valid && !mem_rd, "R1", "in reset", {30'd0, pkt_valid, mem_rd}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!pkt_valid && !mem_rd, "R1", "idle after reset", {30'd0, pkt_valid, mem_rd}, 32'd0);

        // R4 R2 R3 R5: each output alone, fast then stalled router
        for (int o = 0; o < N_OUT; o++) begin
            cur_req = (o == 5) ? "R6" : "R4";
            stall_mode = (o % 2) == 1;
            push_out(o);
            fire(N_OUT'(1) << o);
            drain(cur_req);
        end

        // R7: every output in the same cycle
        cur_req = "R7";
        stall_mode = 1'b1;
        for (int o = 0; o < N_OUT; o++) push_out(o);
        fire('1);
        drain("R7");

        // R8: spikes on 1 and 3 during the walk of 3
        cur_req = "R8";
        stall_mode = 1'b0;
        push_out(3);
        push_out(1);
        push_out(3);
        fire(16'h0008);
        while (got < exp_wr - 200) @(negedge clk);
        fire(16'h000A);
        drain("R8");

        // R6: output with an empty row stays silent
        cur_req = "R6";
        fire(16'h0020);
        drain("R6");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule